// File: doc/BRIEF.md
# Multi-Level FSK Deviation Generator

This block converts a serial stream of transmit data bits into a signed frequency offset word that the synthesizer adds to its fractional divider value. The offset is expressed in fractional-N LSB units, where one LSB equals 2^-16 of the phase-detector reference frequency. The deviation magnitude comes from an unsigned code that software programs.

In binary mode every strobed bit moves the carrier to plus or minus one deviation. In four-level mode the bits are collected in pairs. Each pair selects one of four levels, at plus or minus one and plus or minus three times the deviation, using a Gray-ordered map. When the RF output runs through a divide-by-two stage, a flag halves the offset so that the deviation seen on air stays the same.

The output is registered. It changes only at the clock edge that completes a symbol and holds its value between symbols. After reset it is zero, which is the carrier centre.

Top module: `fsk_dev_gen`

## Requirements
- R1: While reset is asserted and after it is released, `offset_o` reads 0 until the first symbol completes, and no first bit of a four-level pair is pending.
- R2: When `mode_i` is any value other than 3'b001 (3'b000 is the binary setting), each sampled `bit_stb_i` completes a symbol. `bit_i`=1 gives +dev and `bit_i`=0 gives -dev, and `offset_o` shows the new value right after the clock edge that sampled the strobe.
- R3: When `mode_i` = 3'b001, strobed bits are taken in pairs, and the first bit is the MSB of the pair. The map is 00 to -3·dev, 01 to -1·dev, 11 to +1·dev and 10 to +3·dev. `offset_o` updates at the edge that samples the second bit.
- R4: With `div2_i` low, dev equals `code_i` in LSB units, and a code of 0 behaves as a code of 1.
- R5: With `div2_i` high, the magnitude is (m·dev + 1) / 2 rounded down, where m is 1 or 3. The sign is applied afterwards, so positive and negative levels stay symmetric.
- R6: `offset_o` holds its value in every cycle that completes no symbol. This includes the first bit of a four-level pair and any change of `code_i`, `div2_i` or `mode_i` without a strobe.
- R7: In any cycle where `mode_i` is not 3'b001, a pending first bit is discarded, so the next four-level symbol starts with a fresh pair.
- R8: `offset_o` never lies outside ±3·(2^CODE_W - 1) and is never zero once a symbol has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Modulation select: 3'b001 four-level, any other value binary |
| code_i | input | CODE_W | Unsigned deviation code |
| div2_i | input | 1 | Halve the deviation for the divided RF path |
| bit_stb_i | input | 1 | Qualifies `bit_i` for one cycle |
| bit_i | input | 1 | Transmit data bit |
| offset_o | output | CODE_W+3 | Signed frequency offset in fractional-N LSB units |

## Verification
The assertions check on every cycle that the output holds when no symbol completes and that it stays inside the ±3·max bound. They also check that it is never zero after an update, that a binary symbol's sign follows the data bit, that magnitudes are exact multiples of the effective code when halving is off, and that leaving four-level mode clears a pending half pair. Only the bench's scenarios can show the full Gray map for every pair, the rounding of halved odd products, the code-0 substitution at both halving settings, and a four-level pair broken by a mode change and then restarted from a fresh first bit.

// File: rtl/fskdev_pkg.sv
package fskdev_pkg;

  typedef enum logic [2:0] {
    MODE_BIN  = 3'b000,
    MODE_QUAD = 3'b001
  } fsk_mode_e;

  // Symbol level selection: sign and whether the magnitude is tripled
  typedef struct packed {
    logic neg;
    logic triple;
  } level_t;

  // Gray-ordered four-level map; binary uses the bit as sign only
  function automatic level_t level_of(logic quad, logic [1:0] sym);
    level_t l;
    if (quad) begin
      unique case (sym)
        2'b00:   begin l.neg = 1'b1; l.triple = 1'b1; end
        2'b01:   begin l.neg = 1'b1; l.triple = 1'b0; end
        2'b11:   begin l.neg = 1'b0; l.triple = 1'b0; end
        default: begin l.neg = 1'b0; l.triple = 1'b1; end
      endcase
    end else begin
      l.neg    = ~sym[0];
      l.triple = 1'b0;
    end
    return l;
  endfunction

  // Unsigned magnitude of the offset for one level
  function automatic int unsigned dev_mag(int unsigned code, logic triple, logic half);
    int unsigned eff;
    int unsigned prod;
    eff  = (code == 0) ? 1 : code;
    prod = triple ? (eff * 3) : eff;
    return half ? ((prod + 1) >> 1) : prod;
  endfunction

endpackage

// File: rtl/fskdev_sym_asm.sv
module fskdev_sym_asm (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       quad_i,
  input  logic       bit_stb_i,
  input  logic       bit_i,
  output logic       sym_done_o,
  output logic [1:0] sym_o,
  output logic       pend_o
);

  logic pend_q;
  logic first_q;

  // A symbol completes on every bit in binary mode, on the second bit in quad mode
  assign sym_done_o = bit_stb_i & (~quad_i | pend_q);
  assign sym_o      = quad_i ? {first_q, bit_i} : {bit_i, bit_i};
  assign pend_o     = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      first_q <= 1'b0;
    end else if (!quad_i) begin
      pend_q  <= 1'b0;
    end else if (bit_stb_i) begin
      pend_q <= ~pend_q;
      if (!pend_q) first_q <= bit_i;
    end
  end

endmodule

// File: rtl/fskdev_level_map.sv
module fskdev_level_map
  import fskdev_pkg::*;
(
  input  logic       quad_i,
  input  logic [1:0] sym_i,
  output logic       neg_o,
  output logic       triple_o
);

  level_t lvl;

  always_comb begin
    lvl      = level_of(quad_i, sym_i);
    neg_o    = lvl.neg;
    triple_o = lvl.triple;
  end

endmodule

// File: rtl/fskdev_scaler.sv
module fskdev_scaler
  import fskdev_pkg::*;
#(
  parameter int CODE_W = 9
) (
  input  logic                     [CODE_W-1:0] code_i,
  input  logic                                  half_i,
  input  logic                                  neg_i,
  input  logic                                  triple_i,
  output logic signed              [CODE_W+2:0] off_o
);

  localparam int MAG_W = CODE_W + 2;
  localparam int OUT_W = CODE_W + 3;

  logic [MAG_W-1:0] mag;
  logic signed [OUT_W-1:0] pos;

  always_comb begin
    mag   = MAG_W'(dev_mag(int'(code_i), triple_i, half_i));
    pos   = $signed({1'b0, mag});
    off_o = neg_i ? -pos : pos;
  end

endmodule

// File: rtl/fsk_dev_gen.sv
module fsk_dev_gen
  import fskdev_pkg::*;
#(
  parameter int CODE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [2:0]               mode_i,
  input  logic [CODE_W-1:0]        code_i,
  input  logic                     div2_i,
  input  logic                     bit_stb_i,
  input  logic                     bit_i,
  output logic signed [CODE_W+2:0] offset_o
);

  localparam int OUT_W = CODE_W + 3;

  // Named internal events, also used by the checker
  logic                    quad_mode;
  logic                    sym_done;
  logic [1:0]              sym;
  logic                    pair_pend;
  logic                    lvl_neg;
  logic                    lvl_triple;
  logic signed [OUT_W-1:0] next_off;
  logic signed [OUT_W-1:0] off_q;

  assign quad_mode = (mode_i == MODE_QUAD);

  fskdev_sym_asm u_asm (
    .clk        (clk),
    .rst_n      (rst_n),
    .quad_i     (quad_mode),
    .bit_stb_i  (bit_stb_i),
    .bit_i      (bit_i),
    .sym_done_o (sym_done),
    .sym_o      (sym),
    .pend_o     (pair_pend)
  );

  fskdev_level_map u_map (
    .quad_i   (quad_mode),
    .sym_i    (sym),
    .neg_o    (lvl_neg),
    .triple_o (lvl_triple)
  );

  fskdev_scaler #(.CODE_W(CODE_W)) u_scale (
    .code_i   (code_i),
    .half_i   (div2_i),
    .neg_i    (lvl_neg),
    .triple_i (lvl_triple),
    .off_o    (next_off)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        off_q <= '0;
    else if (sym_done) off_q <= next_off;
  end

  assign offset_o = off_q;

endmodule

// File: rtl/fsk_dev_gen_chk.sv
module fsk_dev_gen_chk #(
  parameter int CODE_W = 9
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [2:0]               mode_i,
  input logic [CODE_W-1:0]        code_i,
  input logic                     div2_i,
  input logic                     bit_stb_i,
  input logic                     bit_i,
  input logic signed [CODE_W+2:0] offset_o,
  input logic                     sym_done,
  input logic                     pair_pend
);

  localparam int MAXV = 3 * ((1 << CODE_W) - 1);

  int  abs_off;
  int  eff_code;
  logic quad;

  always_comb begin
    abs_off  = offset_o[CODE_W+2] ? -int'(offset_o) : int'(offset_o);
    eff_code = (code_i == '0) ? 1 : int'(code_i);
    quad     = (mode_i == 3'b001);
  end

  // R6: no completed symbol, no change of the output
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_done |=> $stable(offset_o));

  // R6: a bit strobe that does not complete a pair keeps the output
  a_r6_first_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (quad && bit_stb_i && !pair_pend) |=> $stable(offset_o));

  // R8: magnitude bound
  a_r8_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(offset_o) <= MAXV) && (int'(offset_o) >= -MAXV));

  // R8: never back on the carrier after an update
  a_r8_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    sym_done |=> (offset_o != '0));

  // R2: binary sign follows the data bit
  a_r2_bin_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (!quad && bit_stb_i) |=> (offset_o[CODE_W+2] == !$past(bit_i)));

  // R2, R4: binary magnitude equals effective code when not halved
  a_r4_bin_mag: assert property (@(posedge clk) disable iff (!rst_n)
    (!quad && bit_stb_i && !div2_i) |=> (abs_off == $past(eff_code)));

  // R3: four-level magnitudes are one or three times the effective code
  a_r3_quad_mag: assert property (@(posedge clk) disable iff (!rst_n)
    (quad && sym_done && !div2_i) |=>
      ((abs_off == $past(eff_code)) || (abs_off == 3 * $past(eff_code))));

  // R7: leaving four-level mode drops a pending half pair
  a_r7_pend_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !quad |=> !pair_pend);

  // R1: reset state
  a_r1_reset_zero: assert property (@(posedge clk)
    !rst_n |-> (offset_o == '0) && !pair_pend);

endmodule

bind fsk_dev_gen fsk_dev_gen_chk #(.CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_i    (mode_i),
  .code_i    (code_i),
  .div2_i    (div2_i),
  .bit_stb_i (bit_stb_i),
  .bit_i     (bit_i),
  .offset_o  (offset_o),
  .sym_done  (sym_done),
  .pair_pend (pair_pend)
);

// File: tb/fsk_dev_gen_tb.sv
`timescale 1ns/1ps
module fsk_dev_gen_tb;

  localparam int CODE_W = 9;

  logic                     clk = 1'b0;
  logic                     rst_n = 1'b0;
  logic [2:0]               mode = 3'b000;
  logic [CODE_W-1:0]        code = '0;
  logic                     div2 = 1'b0;
  logic                     stb = 1'b0;
  logic                     dbit = 1'b0;
  logic signed [CODE_W+2:0] offset;

  int checks = 0;
  int errors = 0;

  // Bench-side model state
  bit mdl_pend = 0;
  bit mdl_first = 0;
  int mdl_out = 0;

  always #2.5 clk = ~clk;

  fsk_dev_gen #(.CODE_W(CODE_W)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode),
    .code_i    (code),
    .div2_i    (div2),
    .bit_stb_i (stb),
    .bit_i     (dbit),
    .offset_o  (offset)
  );

  // Expected level per requirements R2..R5
  function automatic int exp_off(bit quad, bit [1:0] pair, int c, bit half);
    int lvl;
    int e;
    int v;
    if (quad) begin
      case (pair)
        2'b00: lvl = -3;
        2'b01: lvl = -1;
        2'b11: lvl = 1;
        default: lvl = 3;
      endcase
    end else begin
      lvl = pair[0] ? 1 : -1;
    end
    e = (c == 0) ? 1 : c;
    v = lvl * e;
    if (half) v = (v > 0) ? (v + 1) / 2 : -((1 - v) / 2);
    return v;
  endfunction

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // Send one bit, then check output after the sampling edge
  task automatic send_bit(bit b, string req);
    bit quad;
    quad = (mode == 3'b001);
    @(negedge clk);
    stb  = 1'b1;
    dbit = b;
    if (!quad) begin
      mdl_out = exp_off(1'b0, {b, b}, int'(code), div2);
    end else if (mdl_pend) begin
      mdl_out  = exp_off(1'b1, {mdl_first, b}, int'(code), div2);
      mdl_pend = 0;
    end else begin
      mdl_first = b;
      mdl_pend  = 1;
    end
    @(negedge clk);
    stb = 1'b0;
    check(req, int'(offset), mdl_out);
  endtask

  task automatic set_mode(logic [2:0] m);
    @(negedge clk);
    mode = m;
    @(negedge clk);
    if (m != 3'b001) mdl_pend = 0;
    check("R6 mode change holds output", int'(offset), mdl_out);
  endtask

  task automatic run_all();
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 offset during reset", int'(offset), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 offset after reset", int'(offset), 0);

    // R2, R4: binary with code 100, then code 0 behaves as 1
    code = 9'd100; div2 = 1'b0;
    send_bit(1'b1, "R2 binary one");
    check("R2 binary +100", int'(offset), 100);
    send_bit(1'b0, "R2 binary zero");
    check("R2 binary -100", int'(offset), -100);
    code = 9'd0;
    send_bit(1'b1, "R4 code zero as one");
    check("R4 code0 +1", int'(offset), 1);
    mode = 3'b110;
    send_bit(1'b0, "R2 other mode value is binary");
    check("R2 mode 110 -1", int'(offset), -1);
    mode = 3'b000;

    // R6: code and halving change without a strobe
    @(negedge clk); code = 9'd300; div2 = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R6 inputs change without strobe", int'(offset), -1);

    // R3: full Gray map at code 511, R8 extremes
    div2 = 1'b0; code = 9'd511;
    set_mode(3'b001);
    send_bit(1'b0, "R6 first bit holds");
    check("R6 first bit no change", int'(offset), -1);
    send_bit(1'b0, "R3 pair 00");
    check("R3 00 -> -1533", int'(offset), -1533);
    send_bit(1'b0, "R6 first bit holds"); send_bit(1'b1, "R3 pair 01");
    check("R3 01 -> -511", int'(offset), -511);
    send_bit(1'b1, "R6 first bit holds"); send_bit(1'b1, "R3 pair 11");
    check("R3 11 -> +511", int'(offset), 511);
    send_bit(1'b1, "R6 first bit holds"); send_bit(1'b0, "R3 pair 10");
    check("R8 10 -> +1533", int'(offset), 1533);

    // R5: halving with odd products and code 1
    div2 = 1'b1; code = 9'd1;
    send_bit(1'b1, "R6 first bit holds"); send_bit(1'b1, "R5 half of 1");
    check("R5 code1 half +1", int'(offset), 1);
    code = 9'd511;
    send_bit(1'b0, "R6 first bit holds"); send_bit(1'b0, "R5 half -3x511");
    check("R5 -767", int'(offset), -767);
    code = 9'd0;
    send_bit(1'b1, "R6 first bit holds"); send_bit(1'b0, "R5 half code0 x3");
    check("R5 code0 +2", int'(offset), 2);

    // R7: break a pair with a mode change, then restart
    div2 = 1'b0; code = 9'd50;
    send_bit(1'b1, "R6 first bit holds");
    set_mode(3'b000);
    set_mode(3'b001);
    send_bit(1'b0, "R7 fresh first bit");
    check("R7 first bit after break holds", int'(offset), 2);
    send_bit(1'b1, "R7 restarted pair 01");
    check("R7 -50", int'(offset), -50);

    // Constrained random mix
    for (int i = 0; i < 600; i++) begin
      if (($urandom % 16) == 0) set_mode((($urandom % 2) == 0) ? 3'b001 : 3'(($urandom % 4) * 2));
      code = CODE_W'($urandom);
      if (($urandom % 8) == 0) code = '0;
      div2 = 1'($urandom);
      send_bit(1'($urandom), "R2/R3/R5 random symbol");
    end
  endtask

  initial begin
    bit timeout;
    timeout = 0;
    void'($urandom(32'd1234));
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        timeout = 1;
      end
    join_any
    disable fork;
    if (timeout) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule